// File: doc/BRIEF.md
# Single-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address for a paged memory with 4 KB pages. It splits the address into a 20-bit virtual page number and a 12-bit page offset. It then reads one entry from a word-addressed page table that starts at the address held in `tableBase`. If the entry is usable, the walker returns the frame number from the entry joined with the unchanged offset. If it is not, the walker returns a page fault or a protection fault.

After a successful translation the walker sets the entry's reference bit. On a write access it also sets the dirty bit. It stores the entry back to memory only when one of those two bits actually changed.

A separate clear pulse starts a sweep over the first `SWEEP_ENTRIES` entries of the table. The sweep clears every reference bit that is set, so that software can later see which pages were touched since the last sweep.

The requester offers a request while `busy` is low and receives a one-cycle response. The memory side carries one outstanding read or write at a time.

Top module: `xlate_walker`

## Requirements
- R1: An accepted translation issues exactly one memory read, at word address `tableBase + vaddr[31:12]`.
- R2: The entry is laid out as follows: bit 0 is valid, bit 1 is write-allowed, bit 2 is referenced, bit 3 is dirty, and bits 31:12 are the frame number. On success, `rspPaddr` equals `{entry[31:12], vaddr[11:0]}`, and both fault flags are low.
- R3: An entry with bit 0 clear answers with `rspPageFault` high, `rspPaddr` zero, and no memory write.
- R4: A write access to a valid entry with bit 1 clear answers with `rspProtFault` high, `rspPageFault` low, `rspPaddr` zero, and no memory write. The two fault flags are never high together.
- R5: A successful translation writes back the entry with bit 2 set. On a write access bit 3 is also set. All other bits are kept.
- R6: When the updated entry equals the entry that was read, no write is issued. The translation then uses exactly one memory access.
- R7: A `clearRefs` pulse makes the walker read each entry from `tableBase` to `tableBase + SWEEP_ENTRIES - 1`. Only entries with bit 2 set are written back, with bit 2 cleared and all other bits kept.
- R8: `busy` is low after reset. It stays high from acceptance until the cycle after the response. `rspValid` lasts one cycle. A `reqValid` while `busy` is high is ignored.
- R9: When `clearRefs` and an accepted request fall in the same cycle, the translation is served first, including its write-back. The sweep runs afterwards.
- R10: While `memReq` is high and `memAck` has not arrived, `memReq`, `memAddr` and `memWrite` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tableBase | input | 32 | Word address of the current page table |
| reqValid | input | 1 | Translation request, taken while busy is low |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Access is a write |
| clearRefs | input | 1 | Pulse: clear all reference bits in the swept range |
| busy | output | 1 | Walker is working |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | 32 | Physical address, zero on a fault |
| rspPageFault | output | 1 | Entry not valid |
| rspProtFault | output | 1 | Write to a write-protected page |
| memReq | output | 1 | Memory access request |
| memWrite | output | 1 | Access is a write |
| memAddr | output | 32 | Word address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | One-cycle completion of the access |

## Verification
A translation and a reference-clear sweep can be requested in the same cycle. The bench provokes this by raising `reqValid` and `clearRefs` on one clock edge, against an entry whose reference bit starts clear. The outcome is judged from the memory-side write log. The first write must be the walk's write-back with bit 2 set, and a later sweep write must clear that bit again. The scoreboard must also receive the translated address.

// File: rtl/xlate_walker_pkg.sv
package xlate_walker_pkg;
  localparam int ENT_VALID = 0;
  localparam int ENT_WRITE = 1;
  localparam int ENT_REF   = 2;
  localparam int ENT_DIRTY = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CHECK, ST_WBACK, ST_DONE, ST_SREAD, ST_SWRITE
  } walkState_t;

  typedef struct packed {
    logic latchReq;
    logic latchEntry;
    logic setPageFault;
    logic setProtFault;
    logic sweepMode;
    logic clrIdx;
    logic incIdx;
  } walkStrobes_t;

  typedef struct packed {
    logic entValid;
    logic entWritable;
    logic entChanged;
    logic reqIsWrite;
    logic idxLast;
  } walkStatus_t;
endpackage

// File: rtl/xlate_walker_dpath.sv
module xlate_walker_dpath
  import xlate_walker_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int OFF_W = 12,
  parameter int SWEEP_ENTRIES = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  walkStrobes_t     strobes,
  input  logic [VA_W-1:0]  tableBase,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic [VA_W-1:0]  memRdata,
  output logic [VA_W-1:0]  memAddr,
  output logic [VA_W-1:0]  memWdata,
  output logic [VA_W-1:0]  rspPaddr,
  output logic             rspPageFault,
  output logic             rspProtFault,
  output walkStatus_t      status
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = (SWEEP_ENTRIES > 1) ? $clog2(SWEEP_ENTRIES) : 1;

  logic [VA_W-1:0]  vaddrQ;
  logic             isWriteQ;
  logic [VA_W-1:0]  entryQ;
  logic [IDX_W-1:0] sweepIdx;
  logic             pageFaultQ, protFaultQ;
  logic [VA_W-1:0]  newEntry;
  logic [VPN_W-1:0] vpn;

  assign vpn = vaddrQ[VA_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaddrQ <= '0;
      isWriteQ <= 1'b0;
      entryQ <= '0;
      sweepIdx <= '0;
      pageFaultQ <= 1'b0;
      protFaultQ <= 1'b0;
    end else begin
      if (strobes.latchReq) begin
        vaddrQ <= reqVaddr;
        isWriteQ <= reqWrite;
        pageFaultQ <= 1'b0;
        protFaultQ <= 1'b0;
      end
      if (strobes.latchEntry) entryQ <= memRdata;
      if (strobes.setPageFault) pageFaultQ <= 1'b1;
      if (strobes.setProtFault) protFaultQ <= 1'b1;
      if (strobes.clrIdx) sweepIdx <= '0;
      else if (strobes.incIdx) sweepIdx <= sweepIdx + 1'b1;
    end
  end

  always_comb begin
    newEntry = entryQ;
    if (strobes.sweepMode) begin
      newEntry[ENT_REF] = 1'b0;
    end else begin
      newEntry[ENT_REF] = 1'b1;
      if (isWriteQ) newEntry[ENT_DIRTY] = 1'b1;
    end
  end

  assign memAddr = tableBase + (strobes.sweepMode ? VA_W'(sweepIdx)
                                                  : {{OFF_W{1'b0}}, vpn});
  assign memWdata = newEntry;

  assign rspPageFault = pageFaultQ;
  assign rspProtFault = protFaultQ;
  assign rspPaddr = (pageFaultQ || protFaultQ) ? '0
                  : {entryQ[VA_W-1:OFF_W], vaddrQ[OFF_W-1:0]};

  assign status.entValid    = entryQ[ENT_VALID];
  assign status.entWritable = entryQ[ENT_WRITE];
  assign status.entChanged  = (newEntry != entryQ);
  assign status.reqIsWrite  = isWriteQ;
  assign status.idxLast     = (sweepIdx == IDX_W'(SWEEP_ENTRIES - 1));
endmodule

// File: rtl/xlate_walker_ctrl.sv
module xlate_walker_ctrl
  import xlate_walker_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         clearRefs,
  input  logic         memAck,
  input  logic         memRefBit,
  input  walkStatus_t  status,
  output walkStrobes_t strobes,
  output logic         busy,
  output logic         memReq,
  output logic         memWrite,
  output logic         rspValid
);
  walkState_t state, stateNext;
  logic pendClear, pendClearNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pendClear <= 1'b0;
    end else begin
      state <= stateNext;
      pendClear <= pendClearNext;
    end
  end

  always_comb begin
    stateNext = state;
    strobes = '0;
    pendClearNext = pendClear | clearRefs;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.latchReq = 1'b1;
          stateNext = ST_READ;
        end else if (clearRefs || pendClear) begin
          strobes.clrIdx = 1'b1;
          pendClearNext = 1'b0;
          stateNext = ST_SREAD;
        end
      end
      ST_READ: begin
        if (memAck) begin
          strobes.latchEntry = 1'b1;
          stateNext = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!status.entValid) begin
          strobes.setPageFault = 1'b1;
          stateNext = ST_DONE;
        end else if (status.reqIsWrite && !status.entWritable) begin
          strobes.setProtFault = 1'b1;
          stateNext = ST_DONE;
        end else if (status.entChanged) begin
          stateNext = ST_WBACK;
        end else begin
          stateNext = ST_DONE;
        end
      end
      ST_WBACK: if (memAck) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      ST_SREAD: begin
        strobes.sweepMode = 1'b1;
        if (memAck) begin
          strobes.latchEntry = 1'b1;
          if (memRefBit) stateNext = ST_SWRITE;
          else if (status.idxLast) stateNext = ST_IDLE;
          else strobes.incIdx = 1'b1;
        end
      end
      ST_SWRITE: begin
        strobes.sweepMode = 1'b1;
        if (memAck) begin
          if (status.idxLast) stateNext = ST_IDLE;
          else begin
            strobes.incIdx = 1'b1;
            stateNext = ST_SREAD;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign memReq = (state == ST_READ) || (state == ST_WBACK) ||
                  (state == ST_SREAD) || (state == ST_SWRITE);
  assign memWrite = (state == ST_WBACK) || (state == ST_SWRITE);
  assign rspValid = (state == ST_DONE);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_walker_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int OFF_W = 12,
  parameter int SWEEP_ENTRIES = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] tableBase,
  input  logic            reqValid,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic            reqWrite,
  input  logic            clearRefs,
  output logic            busy,
  output logic            rspValid,
  output logic [VA_W-1:0] rspPaddr,
  output logic            rspPageFault,
  output logic            rspProtFault,
  output logic            memReq,
  output logic            memWrite,
  output logic [VA_W-1:0] memAddr,
  output logic [VA_W-1:0] memWdata,
  input  logic [VA_W-1:0] memRdata,
  input  logic            memAck
);
  walkStrobes_t strobes;
  walkStatus_t  status;

  xlate_walker_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .clearRefs(clearRefs),
    .memAck(memAck), .memRefBit(memRdata[ENT_REF]), .status(status),
    .strobes(strobes), .busy(busy), .memReq(memReq), .memWrite(memWrite),
    .rspValid(rspValid)
  );

  xlate_walker_dpath #(.VA_W(VA_W), .OFF_W(OFF_W), .SWEEP_ENTRIES(SWEEP_ENTRIES)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .tableBase(tableBase),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .rspPaddr(rspPaddr),
    .rspPageFault(rspPageFault), .rspProtFault(rspProtFault), .status(status)
  );
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            rspValid,
  input logic            rspPageFault,
  input logic            rspProtFault,
  input logic            memReq,
  input logic            memWrite,
  input logic [VA_W-1:0] memAddr,
  input logic            memAck
);
  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);
  assert_rsp_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> busy);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!memReq && !rspValid));
  assert_fault_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rspPageFault && rspProtFault && rspValid));
  assert_fault_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspPageFault) |-> !memWrite);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite)));
endmodule

bind xlate_walker xlate_walker_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rspValid(rspValid),
  .rspPageFault(rspPageFault), .rspProtFault(rspProtFault),
  .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memAck(memAck)
);

// File: tb/xlate_walker_tb.sv
module xlate_walker_tb;
  localparam int SWEEP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] tableBase = 32'h100;
  logic reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic reqWrite = 1'b0;
  logic clearRefs = 1'b0;
  logic busy, rspValid, rspPageFault, rspProtFault, memReq, memWrite;
  logic [31:0] rspPaddr, memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0;

  always #2 clk = ~clk;

  xlate_walker #(.SWEEP_ENTRIES(SWEEP)) u_dut (.*);

  int checks = 0, fails = 0;
  int reads = 0, writes = 0, responses = 0, holdErrs = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] wlogAddr [$];
  logic [31:0] wlogData [$];
  logic [31:0] expPaddr [$];
  logic expPf [$];
  logic expPrf [$];
  logic pendPrev = 1'b0;
  logic [31:0] addrPrev = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle ack, one access at a time
  always @(posedge clk) begin
    if (!rst_n) begin
      memAck <= 1'b0;
      pendPrev <= 1'b0;
    end else begin
      if (pendPrev && (!memReq || memAddr != addrPrev)) holdErrs++;
      pendPrev <= memReq && !memAck;
      addrPrev <= memAddr;
      if (memReq && !memAck) begin
        memAck <= 1'b1;
        if (memWrite) begin
          mem[memAddr[9:0]] <= memWdata;
          writes++;
          wlogAddr.push_back(memAddr);
          wlogData.push_back(memWdata);
        end else begin
          memRdata <= mem[memAddr[9:0]];
          reads++;
        end
      end else begin
        memAck <= 1'b0;
      end
    end
  end

  // monitor: compares each response against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rspValid) begin
      responses++;
      if (expPaddr.size() == 0) begin
        chk(1'b0, "R8", "unexpected response", rspPaddr, 32'h0);
      end else begin
        logic [31:0] ep;
        logic epf, eprf;
        ep = expPaddr.pop_front();
        epf = expPf.pop_front();
        eprf = expPrf.pop_front();
        chk(rspPaddr == ep, "R2", "paddr", rspPaddr, ep);
        chk(rspPageFault == epf, "R3", "page fault", {31'b0, rspPageFault}, {31'b0, epf});
        chk(rspProtFault == eprf, "R4", "prot fault", {31'b0, rspProtFault}, {31'b0, eprf});
      end
    end
  end

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic doReq(input logic [31:0] va, input logic wr,
                       input logic [31:0] ep, input logic epf, input logic eprf,
                       input int expWrites, input string req);
    int r0, w0;
    expPaddr.push_back(ep);
    expPf.push_back(epf);
    expPrf.push_back(eprf);
    r0 = reads;
    w0 = writes;
    reqValid = 1'b1;
    reqVaddr = va;
    reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    chk(reads - r0 == 1, "R1", "read count", 32'(reads - r0), 32'd1);
    chk(writes - w0 == expWrites, req, "write count", 32'(writes - w0), 32'(expWrites));
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[10'h110] = 32'h0002_2001;
    mem[10'h105] = 32'h0004_5003;
    mem[10'h108] = 32'h0007_8007;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && rspValid == 1'b0 && memReq == 1'b0, "R8", "reset state",
        {29'b0, busy, rspValid, memReq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R5: worked translation, reference bit written back
    wlogAddr.delete();
    doReq(32'h0001_0020, 1'b0, 32'h0002_2020, 1'b0, 1'b0, 1, "R5");
    chk(wlogAddr.size() > 0 && wlogAddr[0] == 32'h110, "R1", "entry address",
        wlogAddr.size() > 0 ? wlogAddr[0] : 32'hx, 32'h110);
    chk(mem[10'h110] == 32'h0002_2005, "R5", "ref set", mem[10'h110], 32'h0002_2005);

    // R6: entry already referenced, no write-back
    doReq(32'h0001_0020, 1'b0, 32'h0002_2020, 1'b0, 1'b0, 0, "R6");

    // R4: write to write-protected page
    doReq(32'h0001_0fff, 1'b1, 32'h0, 1'b0, 1'b1, 0, "R4");
    chk(mem[10'h110] == 32'h0002_2005, "R4", "entry untouched", mem[10'h110], 32'h0002_2005);

    // R5: write access sets reference and dirty
    doReq(32'h0000_5abc, 1'b1, 32'h0004_5abc, 1'b0, 1'b0, 1, "R5");
    chk(mem[10'h105] == 32'h0004_500f, "R5", "dirty set", mem[10'h105], 32'h0004_500f);

    // R6: already referenced read
    doReq(32'h0000_8444, 1'b0, 32'h0007_8444, 1'b0, 1'b0, 0, "R6");

    // R3: invalid entry
    doReq(32'h0000_7123, 1'b0, 32'h0, 1'b1, 1'b0, 0, "R3");
    chk(mem[10'h107] == 32'h0, "R3", "invalid entry untouched", mem[10'h107], 32'h0);

    // R8: request while busy is ignored
    begin
      int n0;
      n0 = responses;
      expPaddr.push_back(32'h0007_8001);
      expPf.push_back(1'b0);
      expPrf.push_back(1'b0);
      reqValid = 1'b1;
      reqVaddr = 32'h0000_8001;
      reqWrite = 1'b0;
      @(negedge clk);
      reqValid = 1'b0;
      @(negedge clk);
      reqValid = 1'b1;
      reqVaddr = 32'h0000_7123;
      @(negedge clk);
      reqValid = 1'b0;
      waitIdle();
      repeat (4) @(negedge clk);
      chk(responses - n0 == 1, "R8", "responses while busy", 32'(responses - n0), 32'd1);
    end

    // R7: clear sweep alone
    begin
      int r0, w0;
      r0 = reads;
      w0 = writes;
      clearRefs = 1'b1;
      @(negedge clk);
      clearRefs = 1'b0;
      waitIdle();
      chk(reads - r0 == SWEEP, "R7", "sweep reads", 32'(reads - r0), 32'(SWEEP));
      chk(writes - w0 == 3, "R7", "sweep writes", 32'(writes - w0), 32'd3);
      chk(mem[10'h110] == 32'h0002_2001, "R7", "entry 0x110", mem[10'h110], 32'h0002_2001);
      chk(mem[10'h105] == 32'h0004_500b, "R7", "entry 0x105", mem[10'h105], 32'h0004_500b);
      chk(mem[10'h108] == 32'h0007_8003, "R7", "entry 0x108", mem[10'h108], 32'h0007_8003);
    end

    // R9: request and clear in the same cycle
    begin
      int w0;
      w0 = writes;
      wlogAddr.delete();
      wlogData.delete();
      expPaddr.push_back(32'h0002_2020);
      expPf.push_back(1'b0);
      expPrf.push_back(1'b0);
      reqValid = 1'b1;
      reqVaddr = 32'h0001_0020;
      reqWrite = 1'b0;
      clearRefs = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      clearRefs = 1'b0;
      waitIdle();
      repeat (2) @(negedge clk);
      waitIdle();
      chk(wlogData.size() > 0 && wlogData[0] == 32'h0002_2005, "R9", "walk write first",
          wlogData.size() > 0 ? wlogData[0] : 32'hx, 32'h0002_2005);
      chk(writes - w0 == 2, "R9", "total writes", 32'(writes - w0), 32'd2);
      chk(mem[10'h110] == 32'h0002_2001, "R9", "ref cleared after", mem[10'h110], 32'h0002_2001);
    end

    chk(holdErrs == 0, "R10", "request hold violations", 32'(holdErrs), 32'd0);
    chk(expPaddr.size() == 0, "R8", "missing responses", 32'(expPaddr.size()), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule